// File: doc/BRIEF.md
# Threshold-Triggered Accumulating Listener

This block is a passive monitor that sits beside a data line and watches two 9-bit quantities on it: a sample value and an increment value. When a non-zero increment is seen and the listener is quiet, it starts a scripted sequence. It loads a running accumulator from a reload value supplied from outside. It pauses for one clock. It then either reports the loaded value once or enters a loop. Each pass of the loop adds the increment and reports the sum. Each report appears on a registered output as a one-cycle valid strobe with the value beside it.

A separate supervising routine, the guardian, takes over when the sample rises above the upper threshold. From the cycle after it activates, the accumulation sequence is frozen in whatever step it had reached. The guardian then waits for the sample to fall below the lower threshold. When it does, the guardian spends one cycle returning the sequence to idle and clearing the accumulator, and then goes idle itself. Both thresholds are compile-time parameters, with defaults of 3 (lower) and 9 (upper). All comparisons are strict.

Top module: `thresh_accum_listener`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, the outputs read `flush_vld_o`=0 and `flush_dat_o`=0, and both routines are idle.
- R2: At a clock edge where the sequence is idle, the guardian is idle and `inc_i` is non-zero, the accumulator is loaded from `reload_i` and the sequence starts. An increment of zero starts nothing.
- R3: The cycle that follows a start is a sleep step that reports nothing. The input is first evaluated one cycle after the sleep, so the first strobe is seen after the third clock edge, counting the start edge.
- R4: If at evaluation `smp_i` < lower threshold, the unchanged accumulator is reported exactly once and the sequence returns to idle.
- R5: Otherwise, each loop iteration (the evaluation cycle included) adds `inc_i` to the accumulator modulo 512 and reports the new sum in that cycle's strobe.
- R6: The loop exit condition, `smp_i` > upper threshold, is tested at the start of each iteration. When it holds, that iteration neither adds nor reports, and the sequence returns to idle.
- R7: The guardian activates at an edge where it is idle and `smp_i` > upper threshold. From the next cycle on, while it is active, the sequence neither advances nor reports.
- R8: An active guardian waits until `smp_i` < lower threshold. It then spends one cycle returning the sequence to idle with the accumulator cleared, and after that it is idle again. A new start then shows the full R2/R3 timing.
- R9: Each report is visible one clock after the cycle that produced it, as `flush_vld_o`=1 for that cycle. `flush_dat_o` holds the last reported value until the next report.
- R10: A sample equal to the lower threshold does not count as below it, and a sample equal to the upper threshold does not count as above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 9 | Monitored sample value |
| inc_i | input | 9 | Monitored increment value; non-zero starts a sequence |
| reload_i | input | 9 | External value loaded into the accumulator at start |
| flush_vld_o | output | 1 | One-cycle report strobe |
| flush_dat_o | output | 9 | Reported accumulator value, held between reports |

## Verification
All 512 reload values are run through a start with the sample held at zero. This shows that the loaded value arrives intact and isolates the single-report exit from the loop. All 511 non-zero increments are run through loop iterations and then a threshold exit. This exercises the wrapping sum, and it separates the loop exit from a guardian freeze by looking at when the strobes stop. Directed runs apply samples exactly at each threshold to expose strict comparisons. They also raise the sample during the sleep step, so a frozen evaluation that must never report can be seen. A long pseudo-random mix of samples, increments and reloads is compared cycle by cycle against an arithmetic model built from the requirements.

// File: rtl/lsn_pkg.sv
package lsn_pkg;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_SLEEP = 2'd1,
    PS_EVAL  = 2'd2,
    PS_LOOP  = 2'd3
  } path_st_e;

  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_WAIT  = 2'd1,
    GS_CLEAR = 2'd2
  } grd_st_e;

endpackage

// File: rtl/lsn_thresh_cmp.sv
module lsn_thresh_cmp #(
  parameter int W      = 9,
  parameter int LO_THR = 3,
  parameter int HI_THR = 9
) (
  input  logic [W-1:0] smp_i,
  output logic         below_lo_o,
  output logic         above_hi_o
);

  localparam logic [W-1:0] LO_V = LO_THR[W-1:0];
  localparam logic [W-1:0] HI_V = HI_THR[W-1:0];

  // strict comparisons on both sides
  always_comb begin
    below_lo_o = (smp_i < LO_V);
    above_hi_o = (smp_i > HI_V);
  end

endmodule

// File: rtl/lsn_guardian.sv
module lsn_guardian
  import lsn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic below_lo_i,
  input  logic above_hi_i,
  output logic busy_o,
  output logic clr_o
);

  grd_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GS_IDLE:  if (above_hi_i) st_d = GS_WAIT;
      GS_WAIT:  if (below_lo_i) st_d = GS_CLEAR;
      GS_CLEAR: st_d = GS_IDLE;
      default:  st_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= GS_IDLE;
    else     st_q <= st_d;
  end

  assign busy_o = (st_q != GS_IDLE);
  assign clr_o  = (st_q == GS_CLEAR);

  // R7: an out-of-range sample seen while idle activates the guardian
  p_grd_trigger_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && above_hi_i) |=> busy_o);

  // R8: the guardian keeps waiting while the sample has not fallen below the lower threshold
  p_grd_wait_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !clr_o && !below_lo_i) |=> (busy_o && !clr_o));

  // R8: the clearing step lasts exactly one cycle
  p_grd_clear_once_r8: assert property (@(posedge clk) disable iff (rst)
    clr_o |=> !busy_o);

endmodule

// File: rtl/lsn_path_seq.sv
module lsn_path_seq
  import lsn_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         freeze_i,
  input  logic         clr_i,
  input  logic         below_lo_i,
  input  logic         above_hi_i,
  input  logic [W-1:0] inc_i,
  input  logic [W-1:0] reload_i,
  output logic         flush_req_o,
  output logic [W-1:0] flush_val_o
);

  path_st_e     st_q, st_d;
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] sum;

  // modulo-2^W addition: carry out is discarded
  assign sum = acc_q + inc_i;

  always_comb begin
    st_d        = st_q;
    acc_d       = acc_q;
    flush_req_o = 1'b0;
    flush_val_o = acc_q;
    if (clr_i) begin
      st_d  = PS_IDLE;
      acc_d = '0;
    end else if (!freeze_i) begin
      unique case (st_q)
        PS_IDLE: begin
          if (|inc_i) begin
            acc_d = reload_i;
            st_d  = PS_SLEEP;
          end
        end
        PS_SLEEP: st_d = PS_EVAL;
        PS_EVAL: begin
          if (below_lo_i) begin
            flush_req_o = 1'b1;
            st_d        = PS_IDLE;
          end else if (above_hi_i) begin
            st_d = PS_IDLE;
          end else begin
            acc_d       = sum;
            flush_req_o = 1'b1;
            flush_val_o = sum;
            st_d        = PS_LOOP;
          end
        end
        PS_LOOP: begin
          if (above_hi_i) begin
            st_d = PS_IDLE;
          end else begin
            acc_d       = sum;
            flush_req_o = 1'b1;
            flush_val_o = sum;
          end
        end
        default: st_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PS_IDLE;
      acc_q <= '0;
    end else begin
      st_q  <= st_d;
      acc_q <= acc_d;
    end
  end

  // R2: a start loads the reload value
  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_IDLE && !freeze_i && !clr_i && (|inc_i)) |=>
      (st_q == PS_SLEEP && acc_q == $past(reload_i)));

  // R3: the sleep step never reports
  p_sleep_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_SLEEP) |-> !flush_req_o);

  // R5: each unfrozen loop iteration accumulates with wrap
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_LOOP && !freeze_i && !clr_i && !above_hi_i) |=>
      (acc_q == W'($past(acc_q) + $past(inc_i))));

  // R6: an out-of-range sample at the loop head ends the sequence
  p_loop_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_LOOP && !freeze_i && !clr_i && above_hi_i) |=> (st_q == PS_IDLE));

  // R7: a frozen sequence neither reports nor moves
  p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (freeze_i && !clr_i) |-> (!flush_req_o ##1 $stable(st_q)));

  // R8: the guardian's clear leaves the sequence idle and empty
  p_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (st_q == PS_IDLE && acc_q == '0));

endmodule

// File: rtl/lsn_flush_reg.sv
module lsn_flush_reg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_i,
  input  logic [W-1:0] val_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      dat_o <= '0;
    end else begin
      vld_o <= req_i;
      if (req_i) dat_o <= val_i;
    end
  end

  // R9: the strobe follows its request by one cycle
  p_strobe_follow_r9: assert property (@(posedge clk) disable iff (rst)
    req_i |=> (vld_o && dat_o == $past(val_i)));

  // R9: without a request the reported value is held
  p_dat_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!vld_o && $stable(dat_o)));

endmodule

// File: rtl/thresh_accum_listener.sv
module thresh_accum_listener #(
  parameter int W      = 9,
  parameter int LO_THR = 3,
  parameter int HI_THR = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] inc_i,
  input  logic [W-1:0] reload_i,
  output logic         flush_vld_o,
  output logic [W-1:0] flush_dat_o
);

  logic         below_lo;
  logic         above_hi;
  logic         grd_busy;
  logic         grd_clr;
  logic         flush_req;
  logic [W-1:0] flush_val;

  lsn_thresh_cmp #(
    .W(W), .LO_THR(LO_THR), .HI_THR(HI_THR)
  ) i_cmp (
    .smp_i      (smp_i),
    .below_lo_o (below_lo),
    .above_hi_o (above_hi)
  );

  lsn_guardian i_grd (
    .clk        (clk),
    .rst        (rst),
    .below_lo_i (below_lo),
    .above_hi_i (above_hi),
    .busy_o     (grd_busy),
    .clr_o      (grd_clr)
  );

  lsn_path_seq #(.W(W)) i_path (
    .clk         (clk),
    .rst         (rst),
    .freeze_i    (grd_busy),
    .clr_i       (grd_clr),
    .below_lo_i  (below_lo),
    .above_hi_i  (above_hi),
    .inc_i       (inc_i),
    .reload_i    (reload_i),
    .flush_req_o (flush_req),
    .flush_val_o (flush_val)
  );

  lsn_flush_reg #(.W(W)) i_out (
    .clk   (clk),
    .rst   (rst),
    .req_i (flush_req),
    .val_i (flush_val),
    .vld_o (flush_vld_o),
    .dat_o (flush_dat_o)
  );

  // R1: reset leaves the outputs cleared
  p_reset_out_r1: assert property (@(posedge clk)
    rst |=> (!flush_vld_o && flush_dat_o == '0));

endmodule

// File: tb/test_thresh_accum_listener.sv
module test_thresh_accum_listener;

  localparam int CLK_P = 10;
  localparam int W     = 9;
  localparam int LO    = 3;
  localparam int HI    = 9;
  localparam int MODW  = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] smp = '0;
  logic [W-1:0] inc = '0;
  logic [W-1:0] rel = '0;
  logic         vld;
  logic [W-1:0] dat;

  int vectors = 0;
  int bad     = 0;

  // reference model state, built from the requirements
  int m_ps  = 0;   // 0 idle, 1 sleep, 2 eval, 3 loop
  int m_gs  = 0;   // 0 idle, 1 wait, 2 clear
  int m_acc = 0;
  int m_vld = 0;
  int m_dat = 0;

  always #(CLK_P/2) clk = ~clk;

  thresh_accum_listener #(.W(W), .LO_THR(LO), .HI_THR(HI)) i_thresh_accum_listener (
    .clk         (clk),
    .rst         (rst),
    .smp_i       (smp),
    .inc_i       (inc),
    .reload_i    (rel),
    .flush_vld_o (vld),
    .flush_dat_o (dat)
  );

  task automatic model_edge(input int s, input int i, input int r, input bit rs);
    int n_ps, n_gs, n_acc, n_vld, n_dat;
    n_ps = m_ps; n_gs = m_gs; n_acc = m_acc; n_vld = 0; n_dat = m_dat;
    if (rs) begin
      n_ps = 0; n_gs = 0; n_acc = 0; n_dat = 0;
    end else if (m_gs == 2) begin
      n_ps = 0; n_acc = 0; n_gs = 0;
    end else begin
      if (m_gs == 0) begin
        case (m_ps)
          0: if (i != 0) begin n_acc = r; n_ps = 1; end
          1: n_ps = 2;
          2: begin
            if (s < LO) begin n_vld = 1; n_dat = m_acc; n_ps = 0; end
            else if (s > HI) n_ps = 0;
            else begin n_acc = (m_acc + i) % MODW; n_vld = 1; n_dat = n_acc; n_ps = 3; end
          end
          default: begin
            if (s > HI) n_ps = 0;
            else begin n_acc = (m_acc + i) % MODW; n_vld = 1; n_dat = n_acc; end
          end
        endcase
        if (s > HI) n_gs = 1;
      end else if (m_gs == 1) begin
        if (s < LO) n_gs = 2;
      end
    end
    m_ps = n_ps; m_gs = n_gs; m_acc = n_acc; m_vld = n_vld; m_dat = n_dat;
  endtask

  task automatic step(input int s, input int i, input int r, input string tag);
    @(negedge clk);
    smp = s[W-1:0]; inc = i[W-1:0]; rel = r[W-1:0];
    model_edge(s, i, r, rst);
    @(posedge clk);
    #1;
    vectors++;
    if (vld !== m_vld[0] || dat !== m_dat[W-1:0]) begin
      bad++;
      $display("FAIL %s: vld=%0b dat=%0d expected vld=%0d dat=%0d", tag, vld, dat, m_vld, m_dat);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    // R1: reset state
    rst = 1'b1;
    for (int k = 0; k < 3; k++) step(k * 5, 7, 100, "R1");
    @(negedge clk); rst = 1'b0;
    step(0, 0, 0, "R1");

    // R2: zero increment never starts a sequence
    for (int k = 0; k < 9; k++) step(k, 0, 77, "R2");

    // R3/R4: every reload value, single report with low sample
    for (int r = 0; r < MODW; r++) begin
      step(0, 1, r, "R2");
      step(0, 0, 0, "R3");
      step(0, 0, 0, "R3");
      step(0, 0, 0, "R4");
      step(5, 0, 0, "R9");
    end

    // R5/R6/R7/R8: every non-zero increment through the loop and out
    for (int i = 1; i < MODW; i++) begin
      step(5, i, 500, "R2");
      step(5, i, 0, "R3");
      step(5, i, 0, "R5");
      step(5, i, 0, "R5");
      step(6, i, 0, "R5");
      step(12, i, 0, "R6");
      step(12, 0, 0, "R7");
      step(1, 0, 0, "R8");
      step(1, 0, 0, "R8");
    end

    // R10: samples exactly at the thresholds keep the loop running
    step(LO, 4, 300, "R10");
    step(LO, 4, 0, "R10");
    step(LO, 4, 0, "R10");
    step(HI, 4, 0, "R10");
    step(HI, 4, 0, "R10");
    step(HI + 1, 0, 0, "R6");
    step(LO, 0, 0, "R10");
    step(LO - 1, 0, 0, "R8");
    step(0, 0, 0, "R8");

    // R7/R8: guardian raised during sleep freezes the evaluation
    step(5, 2, 42, "R2");
    step(20, 2, 0, "R7");
    for (int k = 0; k < 6; k++) step(5, 2, 0, "R7");
    step(LO, 2, 0, "R8");
    step(0, 0, 0, "R8");
    step(0, 0, 0, "R8");
    step(5, 0, 0, "R8");
    step(5, 0, 0, "R8");
    step(4, 9, 11, "R8");
    step(4, 9, 0, "R8");
    step(4, 9, 0, "R8");
    step(4, 0, 0, "R5");
    step(12, 0, 0, "R6");
    step(0, 0, 0, "R8");
    step(0, 0, 0, "R8");

    // mixed pseudo-random run
    seed = 32'h1234_5678;
    for (int k = 0; k < 20000; k++) begin
      int s, i, r;
      seed = seed * 32'd1103515245 + 32'd12345;
      s = int'((seed >> 8) % 14);
      i = ((seed >> 20) % 4 == 0) ? 0 : int'((seed >> 12) % MODW);
      r = int'((seed >> 3) % MODW);
      step(s, i, r, "R5 R7 mix");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

endmodule